// File: doc/BRIEF.md
# Saturating Two-Digit Decimal Ticket Counter

This block counts customers for a service-counter display. Each single-cycle advance pulse adds one to a two-digit decimal count held as a pair of BCD digits. The count starts at 00 and climbs to a fixed ceiling of 80. Once there it freezes until a clear pulse brings it back to 00.

Both digits are shown on one shared seven-segment bus. A free-running refresh divider alternates which digit is enabled, so both digits appear lit at once. A held flag reports when the ceiling has been reached. Debouncing happens upstream: inputs arrive as one-clock pulses synchronous to `clk_i`.

Top module: `ticket_counter`

## Requirements
- R1: After `rst_ni` is released and before any pulse, the display shows 00, `dig_en_o` is 2'b01 (ones digit enabled) and `at_limit_o` is 0.
- R2: An `next_i` pulse below the ceiling raises the displayed value by exactly one, visible from the clock edge that samples it. With no pulse the value holds.
- R3: When the ones digit is 9, an advance sets it to 0 and raises the tens digit by one (for example 09 becomes 10, and 79 becomes 80).
- R4: At 80, further `next_i` pulses are ignored and the display stays 80.
- R5: A `clear_i` pulse returns the display to 00 from any value, including 80.
- R6: When `clear_i` and `next_i` arrive in the same cycle, the clear wins and the result is 00.
- R7: Exactly one bit of `dig_en_o` is high at any time. Bit 0 enables the ones digit and bit 1 the tens digit. The enabled digit changes every `REFRESH_DIV` clock cycles.
- R8: `seg_o` carries the enabled digit active-high, with bit 0 = segment a through bit 6 = segment g. The codes for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R9: `at_limit_o` is high exactly while the count equals 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| next_i | input | 1 | One-cycle advance pulse |
| clear_i | input | 1 | One-cycle clear pulse |
| seg_o | output | 7 | Segments a..g of the enabled digit, active high |
| dig_en_o | output | 2 | Digit enables: bit 0 ones, bit 1 tens |
| at_limit_o | output | 1 | High while the count is 80 |

## Verification
The bench drives the ones-to-tens carry at 09 and 79. A design with a broken carry would show 0A-style blanks, would skip the tens step, or would wrap to 00. It pushes extra advances at 80, where a counter that does not saturate would show 81. It also sends a clear at 80 and a clear together with an advance, which exposes a stuck ceiling or the wrong priority. The multiplexed display is read back per digit, and the dwell time of each enable is measured. A swapped enable, a wrong segment order or a wrong divider period shows up as a miscompare.

// File: rtl/tkt_pkg.sv
package tkt_pkg;
  localparam int NDIG = 2;
  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  // bit0=a .. bit6=g, active high; non-decimal codes blank
  function automatic seg_t bcd_to_seg(bcd_t d);
    case (d)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/tkt_bcd_digit.sv
module tkt_bcd_digit
  import tkt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output bcd_t q_o,
  output logic wrap_o
);
  bcd_t q_q;

  assign wrap_o = (q_q == 4'd9);
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (clr_i)   q_q <= '0;
    else if (inc_i)   q_q <= wrap_o ? 4'd0 : q_q + 4'd1;
  end
endmodule

// File: rtl/tkt_count_core.sv
module tkt_count_core
  import tkt_pkg::*;
#(
  parameter int LIMIT = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic next_i,
  input  logic clear_i,
  output bcd_t ones_o,
  output bcd_t tens_o,
  output logic at_limit_o
);
  localparam int LIM_ONES = LIMIT % 10;
  localparam int LIM_TENS = LIMIT / 10;

  bcd_t digit [NDIG];
  logic wrap  [NDIG];
  logic inc   [NDIG];
  logic stop;

  assign stop = (digit[0] == 4'(LIM_ONES)) && (digit[1] == 4'(LIM_TENS));

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    if (i == 0) begin : g_lsd
      assign inc[i] = next_i & ~stop;
    end else begin : g_upper
      assign inc[i] = inc[i-1] & wrap[i-1];
    end
    tkt_bcd_digit u_dig (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .inc_i  (inc[i]),
      .q_o    (digit[i]),
      .wrap_o (wrap[i])
    );
  end

  assign ones_o     = digit[0];
  assign tens_o     = digit[1];
  assign at_limit_o = stop;
endmodule

// File: rtl/tkt_refresh.sv
module tkt_refresh #(
  parameter int DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sel_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;
  logic         sel_q;
  logic         tick;

  assign tick  = (cnt_q == W'(DIV - 1));
  assign sel_o = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sel_q <= ~sel_q;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/tkt_seg_dec.sv
module tkt_seg_dec
  import tkt_pkg::*;
(
  input  bcd_t d_i,
  output seg_t seg_o
);
  assign seg_o = bcd_to_seg(d_i);
endmodule

// File: rtl/ticket_counter.sv
module ticket_counter
  import tkt_pkg::*;
#(
  parameter int LIMIT       = 80,
  parameter int REFRESH_DIV = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       next_i,
  input  logic       clear_i,
  output logic [6:0] seg_o,
  output logic [1:0] dig_en_o,
  output logic       at_limit_o
);
  bcd_t ones_q, tens_q, shown;
  logic sel;

  tkt_count_core #(.LIMIT(LIMIT)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .next_i     (next_i),
    .clear_i    (clear_i),
    .ones_o     (ones_q),
    .tens_o     (tens_q),
    .at_limit_o (at_limit_o)
  );

  tkt_refresh #(.DIV(REFRESH_DIV)) u_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_o  (sel)
  );

  assign shown    = sel ? tens_q : ones_q;
  assign dig_en_o = sel ? 2'b10 : 2'b01;

  tkt_seg_dec u_dec (
    .d_i   (shown),
    .seg_o (seg_o)
  );
endmodule

// File: rtl/ticket_counter_chk.sv
module ticket_counter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       next_i,
  input logic       clear_i,
  input logic [6:0] seg_o,
  input logic [1:0] dig_en_o,
  input logic       at_limit_o,
  input logic [3:0] ones_q,
  input logic [3:0] tens_q
);
  logic [6:0] val;
  assign val = 7'(tens_q) * 7'd10 + 7'(ones_q);

  p_onehot_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dig_en_o) == 1);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_i && !clear_i && !at_limit_o |=> val == $past(val) + 7'd1);

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !next_i && !clear_i |=> $stable(val));

  p_bcd_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 4'd9 && tens_q <= 4'd9);

  p_hold_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_limit_o && !clear_i |=> at_limit_o && $stable(val));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> val == 7'd0);

  p_ceiling_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val <= 7'd80);

  p_seg_lit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o != 7'h00);
endmodule

bind ticket_counter ticket_counter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .next_i     (next_i),
  .clear_i    (clear_i),
  .seg_o      (seg_o),
  .dig_en_o   (dig_en_o),
  .at_limit_o (at_limit_o),
  .ones_q     (ones_q),
  .tens_q     (tens_q)
);

// File: tb/tb_ticket_counter.sv
module tb_ticket_counter;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nxt = 1'b0;
  logic       clr = 1'b0;
  logic [6:0] seg;
  logic [1:0] en;
  logic       lim;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  ticket_counter #(.LIMIT(80), .REFRESH_DIV(DIV)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .next_i     (nxt),
    .clear_i    (clr),
    .seg_o      (seg),
    .dig_en_o   (en),
    .at_limit_o (lim)
  );

  typedef struct packed {
    logic       nx;
    logic       cl;
    logic [6:0] exp;
    logic       lim;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 7'd1, 1'b0},
    '{1'b1, 1'b0, 7'd2, 1'b0},
    '{1'b0, 1'b0, 7'd2, 1'b0},
    '{1'b1, 1'b0, 7'd3, 1'b0},
    '{1'b0, 1'b1, 7'd0, 1'b0},
    '{1'b1, 1'b0, 7'd1, 1'b0},
    '{1'b1, 1'b1, 7'd0, 1'b0},
    '{1'b1, 1'b0, 7'd1, 1'b0},
    '{1'b1, 1'b0, 7'd2, 1'b0},
    '{1'b0, 1'b1, 7'd0, 1'b0}
  };

  function automatic logic [6:0] seg_of(int d);
    case (d)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      3: return 7'h4F;
      4: return 7'h66;
      5: return 7'h6D;
      6: return 7'h7D;
      7: return 7'h07;
      8: return 7'h7F;
      9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic n, input logic c);
    @(negedge clk);
    nxt = n;
    clr = c;
    @(negedge clk);
    nxt = 1'b0;
    clr = 1'b0;
  endtask

  // read both multiplexed digits and compare against the expected value
  task automatic check_disp(input int exp, input string tag);
    logic [6:0] s_one, s_ten;
    while (en != 2'b01) @(negedge clk);
    s_one = seg;
    while (en != 2'b10) @(negedge clk);
    s_ten = seg;
    check(s_one == seg_of(exp % 10), {tag, " ones segs"}, s_one, seg_of(exp % 10));
    check(s_ten == seg_of(exp / 10), {tag, " tens segs"}, s_ten, seg_of(exp / 10));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int run;
    int prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(en == 2'b01, "R1 dig_en", en, 2'b01);
    check(lim == 1'b0, "R1 at_limit", lim, 0);
    check(seg == seg_of(0), "R1 ones segs", seg, seg_of(0));
    check_disp(0, "R1");

    // table walk: R2 step/hold, R5 clear, R6 clear beats next
    for (int i = 0; i < NV; i++) begin
      pulse(VECS[i].nx, VECS[i].cl);
      check(lim == VECS[i].lim, "R9 table at_limit", lim, VECS[i].lim);
      check_disp(int'(VECS[i].exp), (VECS[i].nx && VECS[i].cl) ? "R6 table" : "R2 table");
    end

    // R3 / R8: climb to 79, checking every value on the display
    for (int v = 1; v <= 79; v++) begin
      pulse(1'b1, 1'b0);
      check(lim == 1'b0, "R9 below ceiling", lim, 0);
      check_disp(v, (v % 10 == 0) ? "R3 carry" : "R8 count");
    end

    // R3: 79 -> 80 carry, R9 flag
    pulse(1'b1, 1'b0);
    check(lim == 1'b1, "R9 at ceiling", lim, 1);
    check_disp(80, "R3 79->80");

    // R4: extra advances ignored
    for (int k = 0; k < 3; k++) begin
      pulse(1'b1, 1'b0);
      check(lim == 1'b1, "R4 held flag", lim, 1);
      check_disp(80, "R4 saturate");
    end

    // R6 at ceiling, then R5 from ceiling
    pulse(1'b1, 1'b1);
    check(lim == 1'b0, "R6 both at 80 flag", lim, 0);
    check_disp(0, "R6 both at 80");
    repeat (80) pulse(1'b1, 1'b0);
    check(lim == 1'b1, "R9 reached again", lim, 1);
    pulse(1'b0, 1'b1);
    check(lim == 1'b0, "R5 clear flag", lim, 0);
    check_disp(0, "R5 clear at 80");

    // R7: enable dwell time and one-hot
    @(negedge clk);
    prev = en;
    while (en == prev[1:0]) @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      prev = en;
      run = 0;
      while (en == prev[1:0]) begin
        check($countones(en) == 1, "R7 onehot", en, 1);
        run++;
        @(negedge clk);
      end
      check(run == DIV, "R7 dwell", run, DIV);
      check(en == ~prev[1:0], "R7 alternate", en, ~prev[1:0]);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule